// File: doc/BRIEF.md
# Energy Voice Activity Detector

This block watches a stream of signed audio samples and decides whether someone is speaking. Accepted samples are cut into frames of a fixed number of samples (55 by default, about 5 ms at 11025 Hz). The squared values of the samples in each frame are summed. At the end of the frame that sum is compared with an energy threshold supplied from outside.

A single loud or quiet frame does not change the decision. Speech begins only after a programmable run of consecutive loud frames. It ends only after a separate programmable run of consecutive quiet frames. A frame on the other side of the threshold clears the run that is being counted.

While the block is idle it accepts input samples and throws them away. While speech is active it passes each sample straight through to a downstream valid/ready port. It also raises one-cycle pulses when speech starts and when it ends. The threshold and both run limits are plain inputs that are loaded before operation.

Top module: `energy_vad`

## Requirements
- R1: A synchronous active-high `rst` returns the block to silence: `voice_active` low, both pulses low, the sample position in the frame zero, the energy sum zero and the run count zero.
- R2: A frame is exactly FRAME_LEN (default 55) accepted samples. A sample is accepted in a cycle where `s_valid` and `s_ready` are both high. The frame energy is the sum of the squares of the samples, each read as a 16-bit two's complement value.
- R3: A frame counts as loud only when its energy is strictly greater than `energy_thr`. A frame whose energy equals the threshold counts as quiet.
- R4: In silence, speech is declared when the number of consecutive loud frames reaches `onset_frames`. A value of 0 acts as 1.
- R5: In speech, silence is declared when the number of consecutive quiet frames reaches `offset_frames`. A value of 0 acts as 1.
- R6: In silence, a quiet frame clears the loud run. In speech, a loud frame clears the quiet run.
- R7: `onset_pulse` is high for exactly one cycle, and `voice_active` rises in that same cycle. This is the cycle after the clock edge that accepted the last sample of the deciding frame. `offset_pulse` behaves the same way when `voice_active` falls.
- R8: While `voice_active` is low, `s_ready` is 1 and `m_valid` is 0, so samples are dropped.
- R9: While `voice_active` is high, `m_valid` equals `s_valid`, `m_data` equals `s_data`, and `s_ready` equals `m_ready`.
- R10: `voice_active` changes only in the cycle after a frame-final sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| energy_thr | input | 38 | Frame energy threshold |
| onset_frames | input | 8 | Consecutive loud frames needed to declare speech |
| offset_frames | input | 8 | Consecutive quiet frames needed to declare silence |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready |
| s_data | input | 16 | Signed input sample |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 16 | Gated output sample (zero when not valid) |
| voice_active | output | 1 | High while speech is active |
| onset_pulse | output | 1 | One-cycle pulse when speech starts |
| offset_pulse | output | 1 | One-cycle pulse when speech ends |

## Verification
The assertions assume that the threshold and both run limits are held steady while a frame is being collected. They also assume that `rst` is high from time zero until the first edges have passed. The stimulus changes the limits only between frames. Each frame is built from samples of one magnitude so that its energy is known in advance, and some frames sit exactly on the threshold. Random gaps in `s_valid` and `m_ready` test that only accepted samples advance the frame. Because of the steady inputs, a frame counts as loud or quiet purely from its own samples.

// File: rtl/vad_pkg.sv
package vad_pkg;
   typedef enum logic {
      VAD_SILENT = 1'b0,
      VAD_SPEECH = 1'b1
   } vad_state_e;
endpackage

// File: rtl/vad_frame_energy.sv
module vad_frame_energy #(
   parameter int SAMPLE_W  = 16,
   parameter int FRAME_LEN = 55,
   parameter int ACC_W     = 38
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                take,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [ACC_W-1:0]    thr,
   output logic                frame_end,
   output logic                frame_loud
);
   localparam int IDX_W  = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
   localparam int PROD_W = 2 * SAMPLE_W;
   localparam bit POW2   = (FRAME_LEN == (1 << IDX_W));

   generate
      if (FRAME_LEN < 2) begin : g_bad_len
         $error("FRAME_LEN must be at least 2");
      end
      if (ACC_W < PROD_W + IDX_W) begin : g_bad_acc
         $error("ACC_W too narrow for a full frame of squares");
      end
   endgenerate

   logic [IDX_W-1:0]         idx;
   logic [ACC_W-1:0]         acc;
   logic signed [PROD_W-1:0] prod;
   logic [ACC_W-1:0]         sq;
   logic [ACC_W-1:0]         total;
   logic                     last;

   always_comb begin
      prod  = $signed(sample) * $signed(sample);
      sq    = {{(ACC_W - PROD_W){1'b0}}, prod};
      total = acc + sq;
   end

   generate
      if (POW2) begin : g_wrap
         assign last = &idx;
      end else begin : g_cmp
         assign last = (idx == IDX_W'(FRAME_LEN - 1));
      end
   endgenerate

   assign frame_end  = take && last;
   assign frame_loud = total > thr;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx <= '0;
         acc <= '0;
      end else if (take) begin
         if (last) begin
            idx <= '0;
            acc <= '0;
         end else begin
            idx <= idx + 1'b1;
            acc <= total;
         end
      end
   end

   a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
      idx <= IDX_W'(FRAME_LEN - 1));

endmodule

// File: rtl/vad_debounce.sv
module vad_debounce #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frame_end,
   input  logic             frame_loud,
   input  logic [CNT_W-1:0] on_lim,
   input  logic [CNT_W-1:0] off_lim,
   output logic             active,
   output logic             onset,
   output logic             offset
);
   import vad_pkg::*;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be positive");
      end
   endgenerate

   vad_state_e       state;
   logic [CNT_W-1:0] run;
   logic [CNT_W:0]   run_next;
   logic [CNT_W:0]   eff_lim;
   logic [CNT_W-1:0] sel_lim;
   logic             toward;

   always_comb begin
      sel_lim  = (state == VAD_SPEECH) ? off_lim : on_lim;
      eff_lim  = (sel_lim == '0) ? (CNT_W+1)'(1) : {1'b0, sel_lim};
      run_next = {1'b0, run} + 1'b1;
      toward   = (state == VAD_SPEECH) ? !frame_loud : frame_loud;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= VAD_SILENT;
         run    <= '0;
         onset  <= 1'b0;
         offset <= 1'b0;
      end else begin
         onset  <= 1'b0;
         offset <= 1'b0;
         if (frame_end) begin
            if (!toward) begin
               run <= '0;
            end else if (run_next >= eff_lim) begin
               run <= '0;
               if (state == VAD_SPEECH) begin
                  state  <= VAD_SILENT;
                  offset <= 1'b1;
               end else begin
                  state  <= VAD_SPEECH;
                  onset  <= 1'b1;
               end
            end else begin
               run <= run_next[CNT_W-1:0];
            end
         end
      end
   end

   assign active = (state == VAD_SPEECH);

   a_r7_onset_edge: assert property (@(posedge clk) disable iff (rst)
      onset |-> (active && !$past(active)));
   a_r7_offset_edge: assert property (@(posedge clk) disable iff (rst)
      offset |-> (!active && $past(active)));
   a_r7_pulse_excl: assert property (@(posedge clk) disable iff (rst)
      $onehot0({onset, offset}));

endmodule

// File: rtl/vad_gate.sv
module vad_gate #(
   parameter int SAMPLE_W  = 16,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                active,
   input  logic                s_valid,
   input  logic [SAMPLE_W-1:0] s_data,
   input  logic                m_ready,
   output logic                s_ready,
   output logic                m_valid,
   output logic [SAMPLE_W-1:0] m_data,
   output logic                take
);
   assign s_ready = active ? m_ready : 1'b1;
   assign m_valid = active && s_valid;
   assign take    = s_valid && s_ready;

   generate
      if (ZERO_IDLE) begin : g_zero
         assign m_data = m_valid ? s_data : '0;
      end else begin : g_pass
         assign m_data = s_data;
      end
   endgenerate

   a_r8_idle_drop: assert property (@(posedge clk) disable iff (rst)
      !active |-> (s_ready && !m_valid));

endmodule

// File: rtl/energy_vad.sv
module energy_vad #(
   parameter int SAMPLE_W  = 16,
   parameter int FRAME_LEN = 55,
   parameter int ACC_W     = 38,
   parameter int CNT_W     = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ACC_W-1:0]    energy_thr,
   input  logic [CNT_W-1:0]    onset_frames,
   input  logic [CNT_W-1:0]    offset_frames,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic [SAMPLE_W-1:0] s_data,
   output logic                m_valid,
   input  logic                m_ready,
   output logic [SAMPLE_W-1:0] m_data,
   output logic                voice_active,
   output logic                onset_pulse,
   output logic                offset_pulse
);
   logic take;
   logic frame_end;
   logic frame_loud;

   vad_gate #(.SAMPLE_W(SAMPLE_W), .ZERO_IDLE(1'b1)) u_gate (
      .clk(clk), .rst(rst), .active(voice_active),
      .s_valid(s_valid), .s_data(s_data), .m_ready(m_ready),
      .s_ready(s_ready), .m_valid(m_valid), .m_data(m_data), .take(take)
   );

   vad_frame_energy #(.SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME_LEN), .ACC_W(ACC_W)) u_energy (
      .clk(clk), .rst(rst), .take(take), .sample(s_data), .thr(energy_thr),
      .frame_end(frame_end), .frame_loud(frame_loud)
   );

   vad_debounce #(.CNT_W(CNT_W)) u_deb (
      .clk(clk), .rst(rst), .frame_end(frame_end), .frame_loud(frame_loud),
      .on_lim(onset_frames), .off_lim(offset_frames),
      .active(voice_active), .onset(onset_pulse), .offset(offset_pulse)
   );

   a_r10_frame_boundary: assert property (@(posedge clk) disable iff (rst)
      (voice_active != $past(voice_active)) |-> $past(frame_end));

endmodule

// File: tb/sim_energy_vad.sv
`timescale 1ns/1ps
module sim_energy_vad;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [37:0] energy_thr = '0;
   logic [7:0]  onset_frames = 8'd1;
   logic [7:0]  offset_frames = 8'd1;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic [15:0] s_data = '0;
   logic        m_valid;
   logic        m_ready = 1'b0;
   logic [15:0] m_data;
   logic        voice_active, onset_pulse, offset_pulse;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   energy_vad u0 (
      .clk(clk), .rst(rst), .energy_thr(energy_thr),
      .onset_frames(onset_frames), .offset_frames(offset_frames),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
      .voice_active(voice_active), .onset_pulse(onset_pulse), .offset_pulse(offset_pulse)
   );

   // behavioural reference
   bit     r_act, r_on, r_off;
   int     r_run, r_idx;
   longint r_acc;

   always @(posedge clk) begin
      if (rst) begin
         r_act = 0; r_on = 0; r_off = 0; r_run = 0; r_idx = 0; r_acc = 0;
      end else begin
         r_on = 0; r_off = 0;
         if (s_valid && (r_act ? m_ready : 1'b1)) begin
            longint d;
            longint e;
            d = longint'($signed(s_data));
            e = r_acc + d * d;
            if (r_idx == 54) begin
               bit loud;
               int lim;
               loud = (e > longint'(energy_thr));
               lim = r_act ? int'(offset_frames) : int'(onset_frames);
               if (lim == 0) lim = 1;
               r_idx = 0; r_acc = 0;
               if (loud != r_act) begin
                  r_run = r_run + 1;
                  if (r_run >= lim) begin
                     r_run = 0;
                     if (r_act) r_off = 1; else r_on = 1;
                     r_act = !r_act;
                  end
               end else begin
                  r_run = 0;
               end
            end else begin
               r_idx = r_idx + 1;
               r_acc = e;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk(voice_active == r_act, "R4/R5 voice_active", voice_active, r_act);
      chk(onset_pulse == r_on, "R7 onset_pulse", onset_pulse, r_on);
      chk(offset_pulse == r_off, "R7 offset_pulse", offset_pulse, r_off);
      if (!r_act) begin
         chk(s_ready == 1'b1, "R8 s_ready idle", s_ready, 1);
         chk(m_valid == 1'b0, "R8 m_valid idle", m_valid, 0);
      end else begin
         chk(s_ready == m_ready, "R9 s_ready follows m_ready", s_ready, m_ready);
         chk(m_valid == s_valid, "R9 m_valid follows s_valid", m_valid, s_valid);
         if (s_valid) chk(m_data == s_data, "R9 m_data", m_data, s_data);
      end
   endtask

   // one frame of 55 accepted samples of magnitude amp; alt flips sign per sample
   task automatic frame(input int amp, input bit alt);
      int n = 0;
      bit neg = 0;
      while (n < 55) begin
         @(negedge clk);
         s_valid = ($urandom % 4) != 0;
         m_ready = ($urandom % 4) != 0;
         s_data  = neg ? 16'(-amp) : 16'(amp);
         #1;
         compare_all();
         if (s_valid && (r_act ? m_ready : 1'b1)) begin
            n++;
            if (alt) neg = !neg;
         end
      end
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         s_valid = 0;
         m_ready = 1;
         #1;
         compare_all();
      end
   endtask

   task automatic expect_state(input bit act, input string tag);
      chk(voice_active == act, tag, voice_active, act);
   endtask

   bit done = 0;

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(voice_active == 0, "R1 voice_active after reset", voice_active, 0);
      chk(onset_pulse == 0 && offset_pulse == 0, "R1 pulses after reset", onset_pulse, 0);
      rst = 0;
      energy_thr = 38'd55_000_000;  // amplitude 1000 gives exactly this
      onset_frames = 8'd3;
      offset_frames = 8'd2;
      idle(3);
      // R3: frames exactly on threshold are quiet
      frame(1000, 0); frame(1000, 1); frame(1000, 0); frame(1000, 0);
      idle(2);
      expect_state(0, "R3 equal energy stays silent");
      // R6: broken loud run
      frame(1001, 0); frame(1001, 1); frame(10, 0); frame(1001, 0); frame(1001, 0);
      idle(2);
      expect_state(0, "R6 loud run cleared by quiet frame");
      frame(1001, 1);
      idle(2);
      expect_state(1, "R4 onset after three loud frames");
      // R5/R6 in speech
      frame(10, 0); frame(1001, 0); frame(10, 1);
      idle(2);
      expect_state(1, "R6 quiet run cleared by loud frame");
      frame(-5, 0);
      idle(2);
      expect_state(0, "R5 offset after two quiet frames");
      // zero limits act as one
      onset_frames = 8'd0;
      offset_frames = 8'd0;
      frame(-1001, 0);
      idle(1);
      expect_state(1, "R4 zero onset limit acts as one");
      frame(0, 0);
      idle(1);
      expect_state(0, "R5 zero offset limit acts as one");
      // R2 extreme sample values
      energy_thr = 38'd59_055_800_319;  // 55*32768^2 - 1
      onset_frames = 8'd1;
      offset_frames = 8'd1;
      frame(32767, 1);
      idle(1);
      expect_state(0, "R2 max positive frame below threshold");
      frame(-32768, 0);
      idle(1);
      expect_state(1, "R2 most negative sample squared");
      // R1 mid-speech reset
      @(negedge clk);
      rst = 1;
      @(negedge clk);
      @(negedge clk);
      #1;
      chk(voice_active == 0, "R1 reset during speech", voice_active, 0);
      rst = 0;
      // long random mix
      energy_thr = 38'd55_000_000;
      onset_frames = 8'd2;
      offset_frames = 8'd3;
      for (int f = 0; f < 30; f++) begin
         int a;
         a = (($urandom % 2) != 0) ? 900 + int'($urandom % 200) : int'($urandom % 50);
         frame(a, f[0]);
      end
      idle(4);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule